// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block chooses which pending interrupt a small CPU services next. It collects a bank of maskable request lines, each gated by its own enable bit, an external active-low request pin whose sensing can be level or falling edge, and an active-low non-maskable request pin. It owns the two global mask bits: a maskable-interrupt mask and a non-maskable mask. When a request wins it raises `cpuReq` and presents a registered 16-bit vector address. The address is held until the CPU pulses `cpuAck`, at which point the controller sets the mask bits the way interrupt entry requires.

Software reaches three small registers through a write port and a combinational read port. The first holds the mask bits. The second is a promotion register that lifts one chosen maskable source above all others. The third selects the sensing mode of the external pin. The CPU's return-from-interrupt path hands stacked mask values back through a restore input.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the maskable mask reads 1, the non-maskable mask reads 1, `cpuReq` is 0, the promotion register reads 0xF2 and the external pin is in level mode (config register reads 0).
- R2: Maskable source k (k = 0 is the external pin, k >= 1 is `srcReq[k]`) has vector low byte 0xF2 - 2k, and the non-maskable source has 0xF4; the vector address is 0xFF in the upper byte and the low byte in the lower byte.
- R3: With no promotion match, the active maskable source with the lowest index wins.
- R4: A maskable source is taken only while its `srcEn` bit is 1 and the maskable mask is 0.
- R5: Register address 1 stores write bits [7:1] and reads bit 0 as 0. An active maskable source whose vector low byte matches the stored value outranks every other maskable source.
- R6: A write to register address 1 while the maskable mask is 0 leaves it unchanged.
- R7: In level mode the external pin is recognised only after it is sampled low on two consecutive clock edges.
- R8: Writing 1 to bit 0 of register address 2 selects edge mode. In that mode a falling edge, even a one-cycle low pulse, latches a pending request, and acknowledging the external-pin vector clears it.
- R9: The non-maskable pin, when low and its mask is 0, wins over every maskable source regardless of the maskable mask or promotion.
- R10: Register address 0 holds the maskable mask in bit 0 and the non-maskable mask in bit 1. A write can clear the non-maskable mask but never set it.
- R11: `cpuReq` rises one cycle after a winner appears and the vector stays fixed until `cpuAck`. The cycle after `cpuAck`, `cpuReq` is 0 and the maskable mask is 1, and the non-maskable mask is also 1 if the non-maskable source was served.
- R12: A `rtiRestore` pulse loads both mask bits from `rtiIBit` and `rtiXBit`. For the mask bits, acknowledge has priority over restore, and restore has priority over a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcReq | input | NUM_SRC-1 | Maskable peripheral requests, indices 1 to NUM_SRC-1 |
| srcEn | input | NUM_SRC | Local enables, bit 0 for the external pin |
| irqPinN | input | 1 | External maskable request, active low |
| xirqPinN | input | 1 | Non-maskable request, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 masks, 1 promotion, 2 config |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Read data for `regAddr` |
| cpuAck | input | 1 | CPU accepts the offered vector |
| rtiRestore | input | 1 | Restore mask bits on interrupt return |
| rtiIBit | input | 1 | Maskable mask value to restore |
| rtiXBit | input | 1 | Non-maskable mask value to restore |
| cpuReq | output | 1 | Interrupt offered to the CPU |
| vecAddr | output | 16 | Vector address of the offered interrupt |
| iMask | output | 1 | Maskable-interrupt mask |
| xMask | output | 1 | Non-maskable mask |

## Verification
Two maskable sources are raised together so that the default order, an enable held low, an active promotion and a non-maskable request each pick a different vector. The external pin is driven with a single-cycle low pulse and with a held low level, in both sensing modes. Level mode must reject the pulse, while edge mode must latch it and then drop it after the acknowledge. Mask and promotion writes are issued with the maskable mask both set and clear, and with restore arriving in the same cycle, to separate the write gating from the update priority.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam logic [7:0] IRQ_LOW  = 8'hF2;
  localparam logic [7:0] XIRQ_LOW = 8'hF4;
  localparam logic [7:0] VEC_HIGH = 8'hFF;

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_PROM = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;

  // vector low byte of maskable source k: 0xF2, 0xF0, 0xEE, ...
  function automatic logic [7:0] srcLow(input int k);
    return IRQ_LOW - 8'(k << 1);
  endfunction

  typedef struct packed {
    logic       loadVec;
    logic [7:0] vecLow;
    logic       takeAck;
    logic       ackXirq;
    logic       ackIrq;
  } ctrlStrb_t;

endpackage

// File: rtl/irqc_dpath.sv
module irqc_dpath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:1] srcReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               irqPinN,
  input  logic               xirqPinN,
  input  logic               regWe,
  input  logic [1:0]         regAddr,
  input  logic [7:0]         regWdata,
  input  logic               rtiRestore,
  input  logic               rtiIBit,
  input  logic               rtiXBit,
  input  ctrlStrb_t          strb,
  output logic [NUM_SRC-1:0] cand,
  output logic [NUM_SRC-1:0] promHit,
  output logic               xirqAct,
  output logic               iMask,
  output logic               xMask,
  output logic [15:0]        vecAddr,
  output logic [7:0]         regRdata
);

  localparam logic [6:0] PROM_RST = IRQ_LOW[7:1];

  logic       irqPrevN;
  logic       irqPend;
  logic       edgeMode;
  logic [6:0] promSel;
  logic       irqLevel;
  logic       irqFall;
  logic       irqAct;
  logic [NUM_SRC-1:0] reqAll;

  // external pin sensing
  assign irqLevel = !irqPinN && !irqPrevN;
  assign irqFall  = irqPrevN && !irqPinN;
  assign irqAct   = edgeMode ? irqPend : irqLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPrevN <= 1'b1;
      irqPend  <= 1'b0;
    end else begin
      irqPrevN <= irqPinN;
      if (edgeMode && irqFall)
        irqPend <= 1'b1;
      else if (strb.takeAck && strb.ackIrq)
        irqPend <= 1'b0;
    end
  end

  // candidate requests and promotion match
  assign reqAll  = {srcReq, irqAct};
  assign cand    = reqAll & srcEn & {NUM_SRC{~iMask}};
  assign xirqAct = !xirqPinN && !xMask;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_prom
    localparam logic [7:0] LOW_K = srcLow(k);
    assign promHit[k] = (LOW_K[7:1] == promSel);
  end

  // mask bits: acknowledge, then restore, then software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iMask <= 1'b1;
      xMask <= 1'b1;
    end else if (strb.takeAck) begin
      iMask <= 1'b1;
      if (strb.ackXirq) xMask <= 1'b1;
    end else if (rtiRestore) begin
      iMask <= rtiIBit;
      xMask <= rtiXBit;
    end else if (regWe && regAddr == ADDR_MASK) begin
      iMask <= regWdata[0];
      xMask <= xMask & regWdata[1];
    end
  end

  // promotion and config registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      promSel  <= PROM_RST;
      edgeMode <= 1'b0;
    end else if (regWe) begin
      if (regAddr == ADDR_PROM && iMask) promSel <= regWdata[7:1];
      if (regAddr == ADDR_CFG) edgeMode <= regWdata[0];
    end
  end

  // registered vector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      vecAddr <= 16'h0000;
    else if (strb.loadVec)
      vecAddr <= {VEC_HIGH, strb.vecLow};
  end

  always_comb begin
    case (regAddr)
      ADDR_MASK: regRdata = {6'b0, xMask, iMask};
      ADDR_PROM: regRdata = {promSel, 1'b0};
      ADDR_CFG:  regRdata = {7'b0, edgeMode};
      default:   regRdata = 8'h00;
    endcase
  end

  AST_PROM_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == ADDR_PROM && !iMask |=> $stable(promSel)); // R6

  AST_X_NO_SW_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xMask) |-> $past(strb.takeAck && strb.ackXirq) || $past(rtiRestore)); // R10

  AST_ACK_SETS_I: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeAck |=> iMask); // R11

endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] cand,
  input  logic [NUM_SRC-1:0] promHit,
  input  logic               xirqAct,
  input  logic               cpuAck,
  output ctrlStrb_t          strb,
  output logic               cpuReq
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               reqQ;
  logic               winXQ;
  logic               winIrqQ;
  logic [NUM_SRC-1:0] promCand;
  logic               anyCand;
  logic [IDX_W-1:0]   winIdx;
  logic [7:0]         winLow;
  logic               takeNew;

  assign promCand = cand & promHit;
  assign anyCand  = |cand;

  // lowest index wins; a promoted candidate overrides
  always_comb begin
    winIdx = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (cand[k]) winIdx = IDX_W'(k);
    end
    if (|promCand) begin
      for (int k = NUM_SRC - 1; k >= 0; k--) begin
        if (promCand[k]) winIdx = IDX_W'(k);
      end
    end
  end

  assign winLow  = xirqAct ? XIRQ_LOW : srcLow(int'(winIdx));
  assign takeNew = !reqQ && (xirqAct || anyCand);

  always_comb begin
    strb.loadVec = takeNew;
    strb.vecLow  = winLow;
    strb.takeAck = reqQ && cpuAck;
    strb.ackXirq = winXQ;
    strb.ackIrq  = winIrqQ && !winXQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ    <= 1'b0;
      winXQ   <= 1'b0;
      winIrqQ <= 1'b0;
    end else if (takeNew) begin
      reqQ    <= 1'b1;
      winXQ   <= xirqAct;
      winIrqQ <= !xirqAct && (winIdx == '0);
    end else if (reqQ && cpuAck) begin
      reqQ <= 1'b0;
    end
  end

  assign cpuReq = reqQ;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    reqQ && !cpuAck |=> reqQ); // R11

  AST_XIRQ_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    !reqQ && xirqAct |=> reqQ && winXQ); // R9

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:1] srcReq,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               irqPinN,
  input  logic               xirqPinN,
  input  logic               regWe,
  input  logic [1:0]         regAddr,
  input  logic [7:0]         regWdata,
  output logic [7:0]         regRdata,
  input  logic               cpuAck,
  input  logic               rtiRestore,
  input  logic               rtiIBit,
  input  logic               rtiXBit,
  output logic               cpuReq,
  output logic [15:0]        vecAddr,
  output logic               iMask,
  output logic               xMask
);

  ctrlStrb_t          strb;
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] promHit;
  logic               xirqAct;

  irqc_ctrl #(.NUM_SRC(NUM_SRC)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cand    (cand),
    .promHit (promHit),
    .xirqAct (xirqAct),
    .cpuAck  (cpuAck),
    .strb    (strb),
    .cpuReq  (cpuReq)
  );

  irqc_dpath #(.NUM_SRC(NUM_SRC)) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .srcReq     (srcReq),
    .srcEn      (srcEn),
    .irqPinN    (irqPinN),
    .xirqPinN   (xirqPinN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .rtiRestore (rtiRestore),
    .rtiIBit    (rtiIBit),
    .rtiXBit    (rtiXBit),
    .strb       (strb),
    .cand       (cand),
    .promHit    (promHit),
    .xirqAct    (xirqAct),
    .iMask      (iMask),
    .xMask      (xMask),
    .vecAddr    (vecAddr),
    .regRdata   (regRdata)
  );

  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && !cpuAck |=> $stable(vecAddr)); // R11

endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:1] srcReq = '0;
  logic [N-1:0] srcEn = '0;
  logic         irqPinN = 1'b1;
  logic         xirqPinN = 1'b1;
  logic         regWe = 1'b0;
  logic [1:0]   regAddr = 2'd0;
  logic [7:0]   regWdata = 8'h00;
  logic [7:0]   regRdata;
  logic         cpuAck = 1'b0;
  logic         rtiRestore = 1'b0;
  logic         rtiIBit = 1'b0;
  logic         rtiXBit = 1'b0;
  logic         cpuReq;
  logic [15:0]  vecAddr;
  logic         iMask;
  logic         xMask;

  int    nChecks = 0;
  int    nFails  = 0;
  int    cycles  = 0;
  bit    done    = 1'b0;
  string curTag  = "R1";

  always #2.5 clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(N)) i_irq_prio_ctrl (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .srcEn(srcEn),
    .irqPinN(irqPinN), .xirqPinN(xirqPinN), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cpuAck(cpuAck), .rtiRestore(rtiRestore), .rtiIBit(rtiIBit),
    .rtiXBit(rtiXBit), .cpuReq(cpuReq), .vecAddr(vecAddr),
    .iMask(iMask), .xMask(xMask)
  );

  // ---------------- behavioural reference model ----------------
  bit        mI = 1, mX = 1, mEdge = 0, mPrevN = 1, mPend = 0;
  bit        mReq = 0, mWinX = 0, mWinIrq = 0;
  bit [7:0]  mProm = 8'hF2;
  bit [15:0] mVec = 16'h0000;

  always @(posedge clk) begin
    bit irqOn, ack, take, nWinX, nWinIrq, nI, nX, nPend;
    bit [N-1:0] reqAll;
    bit [15:0] nVec;
    int win, prom;
    if (!rstN) begin
      mI = 1; mX = 1; mEdge = 0; mPrevN = 1; mPend = 0;
      mReq = 0; mWinX = 0; mWinIrq = 0; mProm = 8'hF2; mVec = 16'h0000;
    end else begin
      irqOn = mEdge ? mPend : (!irqPinN && !mPrevN);
      ack = mReq && cpuAck;
      take = 0; nWinX = 0; nWinIrq = 0; nVec = mVec;
      if (!mReq) begin
        if (!xirqPinN && !mX) begin
          take = 1; nWinX = 1; nVec = 16'hFFF4;
        end else begin
          reqAll = {srcReq, irqOn};
          win = -1; prom = -1;
          for (int k = 0; k < N; k++) begin
            if (reqAll[k] && srcEn[k] && !mI) begin
              if (win < 0) win = k;
              if ((242 - 2 * k) == int'(mProm)) prom = k;
            end
          end
          if (prom >= 0) win = prom;
          if (win >= 0) begin
            take = 1; nWinIrq = (win == 0);
            nVec = 16'hFF00 | 16'(242 - 2 * win);
          end
        end
      end
      nPend = mPend;
      if (mEdge && mPrevN && !irqPinN) nPend = 1;
      else if (ack && mWinIrq && !mWinX) nPend = 0;
      nI = mI; nX = mX;
      if (ack) begin nI = 1; if (mWinX) nX = 1; end
      else if (rtiRestore) begin nI = rtiIBit; nX = rtiXBit; end
      else if (regWe && regAddr == 2'd0) begin nI = regWdata[0]; nX = mX & regWdata[1]; end
      if (regWe && regAddr == 2'd1 && mI) mProm = regWdata & 8'hFE;
      if (regWe && regAddr == 2'd2) mEdge = regWdata[0];
      mPend = nPend; mPrevN = irqPinN; mI = nI; mX = nX;
      if (take) begin mReq = 1; mVec = nVec; mWinX = nWinX; mWinIrq = nWinIrq; end
      else if (ack) mReq = 0;
    end
  end

  function automatic bit [7:0] modelRd(input bit [1:0] a);
    case (a)
      2'd0: return {6'b0, mX, mI};
      2'd1: return mProm;
      2'd2: return {7'b0, mEdge};
      default: return 8'h00;
    endcase
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      nChecks++;
      if (cpuReq !== mReq || vecAddr !== mVec || iMask !== mI ||
          xMask !== mX || regRdata !== modelRd(regAddr)) begin
        nFails++;
        $display("FAIL %s cycle %0d: act req=%0d vec=%h i=%0d x=%0d rd=%h exp req=%0d vec=%h i=%0d x=%0d rd=%h",
                 curTag, cycles, cpuReq, vecAddr, iMask, xMask, regRdata,
                 mReq, mVec, mI, mX, modelRd(regAddr));
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit [1:0] a, input bit [7:0] d);
    regWe = 1; regAddr = a; regWdata = d;
    step(1);
    regWe = 0;
  endtask

  task automatic rd(input bit [1:0] a);
    regAddr = a;
    step(1);
  endtask

  task automatic ackIt();
    cpuAck = 1;
    step(1);
    cpuAck = 0;
    step(1);
  endtask

  task automatic restore(input bit i, input bit x);
    rtiRestore = 1; rtiIBit = i; rtiXBit = x;
    step(1);
    rtiRestore = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: act running exp finished");
    finishRun();
  end

  initial begin
    step(3);
    rstN = 1;
    step(1);

    curTag = "R1";
    rd(0); chk("R1 masks", regRdata, 8'h03);
    chk("R1 cpuReq", cpuReq, 0);
    rd(1); chk("R1 promotion", regRdata, 8'hF2);
    rd(2); chk("R1 config", regRdata, 8'h00);

    curTag = "R3";
    wr(0, 8'h02);
    srcEn = '1;
    srcReq[3] = 1; srcReq[5] = 1;
    step(3);
    chk("R11 request up", cpuReq, 1);
    chk("R3 lowest index wins (R2 vector)", vecAddr, 16'hFFEC);
    ackIt();
    chk("R11 request dropped", cpuReq, 0);
    rd(0); chk("R11 ack sets I", regRdata, 8'h03);
    srcReq = '0;
    restore(0, 1);

    curTag = "R4";
    srcEn[3] = 0;
    srcReq[3] = 1; srcReq[5] = 1;
    step(3);
    chk("R4 disabled source skipped", vecAddr, 16'hFFE8);
    ackIt();
    srcReq = '0; srcEn = '1;
    restore(1, 1);
    srcReq[2] = 1;
    step(4);
    chk("R4 I mask blocks", cpuReq, 0);
    srcReq = '0;

    curTag = "R5";
    wr(1, 8'hDF);
    rd(1); chk("R5 bit0 reads 0", regRdata, 8'hDE);
    restore(0, 1);
    curTag = "R6";
    wr(1, 8'hEC);
    rd(1); chk("R6 write ignored with I=0", regRdata, 8'hDE);
    curTag = "R5";
    srcReq[3] = 1; srcReq[10] = 1;
    step(3);
    chk("R5 promoted source wins", vecAddr, 16'hFFDE);
    ackIt();
    srcReq = '0;
    restore(0, 1);

    curTag = "R7";
    irqPinN = 0; step(1); irqPinN = 1;
    step(4);
    chk("R7 one-cycle low ignored", cpuReq, 0);
    irqPinN = 0;
    step(3);
    chk("R7 held low taken", cpuReq, 1);
    chk("R7 pin vector", vecAddr, 16'hFFF2);
    ackIt();
    irqPinN = 1;
    restore(0, 1);

    curTag = "R8";
    wr(2, 8'h01);
    irqPinN = 0; step(1); irqPinN = 1;
    step(3);
    chk("R8 pulse latched", cpuReq, 1);
    chk("R8 pin vector", vecAddr, 16'hFFF2);
    ackIt();
    restore(0, 1);
    step(3);
    chk("R8 pending cleared by ack", cpuReq, 0);
    wr(2, 8'h00);

    curTag = "R9";
    xirqPinN = 0;
    step(3);
    chk("R9 masked by X", cpuReq, 0);
    xirqPinN = 1;
    wr(0, 8'h00);
    rd(0); chk("R10 X cleared by write", regRdata, 8'h00);
    wr(0, 8'h01);
    srcReq[1] = 1; xirqPinN = 0;
    step(3);
    chk("R9 non-maskable wins with I=1", vecAddr, 16'hFFF4);
    ackIt();
    xirqPinN = 1; srcReq = '0;
    rd(0); chk("R11 ack sets X and I", regRdata, 8'h03);

    curTag = "R10";
    wr(0, 8'h00);
    wr(0, 8'h02);
    rd(0); chk("R10 X not set by write", regRdata, 8'h00);

    curTag = "R12";
    restore(1, 1);
    rd(0); chk("R12 restore loads masks", regRdata, 8'h03);
    regWe = 1; regAddr = 2'd0; regWdata = 8'h01;
    rtiRestore = 1; rtiIBit = 0; rtiXBit = 0;
    step(1);
    regWe = 0; rtiRestore = 0;
    rd(0); chk("R12 restore beats write", regRdata, 8'h00);

    step(5);
    finishRun();
  end

endmodule